// File: doc/BRIEF.md
# Bit-sliced 32-bit ALU

This unit is the arithmetic and logic core of a small load/store processor. It is purely combinational. Two 32-bit operands enter, and a 4-bit control code selects the operation. The unit drives a 32-bit result, a flag that is high when that result is all zeros, and a flag for signed overflow. It supports five operations: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. A branch tests two registers for equality by subtracting them and looking at the zero flag.

The datapath is a chain of identical one-bit slices. Each slice forms the AND, the OR and a full-adder sum of its operand bits, and the carry ripples from slice to slice. The control code is packed as `{invert, carry_in, op[1:0]}`.

- The invert bit complements B before it enters the slices.
- The carry-in bit feeds the carry input of bit 0, so subtraction is A + ~B + 1.
- Set-on-less-than runs that same subtraction. It then places the sign of the difference, corrected by the overflow, into bit 0 of the result.

The block has no state and no clock. The house-style state machine therefore does not apply. In its place, a control decoder maps the code onto an enumerated operation kind, and a single output process selects the result from that kind. The decoder names six kinds:

- AND
- OR
- ADD
- SUB
- SLT
- NONE

NONE covers every unlisted code.

Top module: `alu32_sliced`

## Requirements
- R1: Control code 4'b0000 drives result = A & B.
- R2: Control code 4'b0001 drives result = A | B.
- R3: Control code 4'b0010 drives result = (A + B) mod 2^32.
- R4: Control code 4'b1110 drives result = (A - B) mod 2^32, that is A + ~B + 1.
- R5: Control code 4'b1111 drives result bit 0 to 1 when A is less than B as signed 32-bit numbers, and to 0 otherwise. Result bits 31..1 are 0 for this code. The comparison is correct even when the difference overflows.
- R6: zero is 1 exactly when all 32 result bits are 0, for every control code.
- R7: For code 4'b0010, ovf is 1 exactly when A and B have equal sign bits and the sign of the sum differs from them. For code 4'b1110, ovf is 1 exactly when A and B have different sign bits and the sign of the difference differs from the sign of A.
- R8: ovf is 0 for codes 4'b0000, 4'b0001 and 4'b1111.
- R9: Every code other than 0000, 0001, 0010, 1110 and 1111 drives result = 0, zero = 1 and ovf = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| ctrl | input | 4 | Control code {invert, carry_in, op[1:0]} |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
Several operand patterns drive the slice chain, and each one separates a different class of fault:

- **Sign-boundary pairs** (0x7FFFFFFF, 0x80000000, -1, 0, 1). These show whether overflow is taken from the right carries. They also show whether less-than applies the overflow correction, or trusts the raw sign, which is wrong.
- **Equal operands.** These show that subtraction leaves an all-zero result with zero high.
- **All-ones and alternating-bit patterns.** These expose a broken carry ripple across the full width, and confusion between AND and OR.
- **Random operands under every valid code.** These give wide coverage of the carry chain.
- **Every unlisted code.** This confirms that the decoder falls back to a zero result with no overflow.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [2:0] {
        K_AND  = 3'd0,
        K_OR   = 3'd1,
        K_ADD  = 3'd2,
        K_SUB  = 3'd3,
        K_SLT  = 3'd4,
        K_NONE = 3'd5
    } alu_kind_e;

    localparam int CTRL_W = 4;

endpackage

// File: rtl/alu32_ctrl_decode.sv
module alu32_ctrl_decode
    import alu32_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output alu_kind_e         kind,
    output logic              b_inv,
    output logic              c_in
);

    always_comb begin
        unique case (ctrl)
            4'b0000: kind = K_AND;
            4'b0001: kind = K_OR;
            4'b0010: kind = K_ADD;
            4'b1110: kind = K_SUB;
            4'b1111: kind = K_SLT;
            default: kind = K_NONE;
        endcase
    end

    // The upper two bits steer the slices directly; for unused codes the
    // output stage discards whatever the slices compute.
    assign b_inv = ctrl[3];
    assign c_in  = ctrl[2];

endmodule

// File: rtl/alu32_bit_slice.sv
module alu32_bit_slice (
    input  logic a,
    input  logic b,
    input  logic b_inv,
    input  logic cin,
    output logic and_o,
    output logic or_o,
    output logic sum_o,
    output logic cout
);

    logic b_eff;

    assign b_eff = b ^ b_inv;
    assign and_o = a & b;
    assign or_o  = a | b;
    assign sum_o = a ^ b_eff ^ cin;
    assign cout  = (a & b_eff) | (a & cin) | (b_eff & cin);

endmodule

// File: rtl/alu32_result_sel.sv
module alu32_result_sel
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_kind_e        kind,
    input  logic [WIDTH-1:0] and_v,
    input  logic [WIDTH-1:0] or_v,
    input  logic [WIDTH-1:0] sum_v,
    input  logic             less,
    input  logic             ovf_raw,
    output logic [WIDTH-1:0] result,
    output logic             ovf
);

    always_comb begin
        result = '0;
        ovf    = 1'b0;
        unique case (kind)
            K_AND: result = and_v;
            K_OR:  result = or_v;
            K_ADD: begin
                result = sum_v;
                ovf    = ovf_raw;
            end
            K_SUB: begin
                result = sum_v;
                ovf    = ovf_raw;
            end
            K_SLT: result[0] = less;
            K_NONE: result = '0;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/alu32_sliced.sv
module alu32_sliced
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]  a_in,
    input  logic [WIDTH-1:0]  b_in,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [WIDTH-1:0]  result,
    output logic              zero,
    output logic              ovf
);

    localparam int MSB = WIDTH - 1;

    alu_kind_e        kind;
    logic             b_inv;
    logic             c_in;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;
    logic [WIDTH-1:0] sum_v;
    logic             ovf_raw;
    logic             less;

    alu32_ctrl_decode u_dec (
        .ctrl  (ctrl),
        .kind  (kind),
        .b_inv (b_inv),
        .c_in  (c_in)
    );

    assign carry[0] = c_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu32_bit_slice u_slice (
            .a     (a_in[i]),
            .b     (b_in[i]),
            .b_inv (b_inv),
            .cin   (carry[i]),
            .and_o (and_v[i]),
            .or_o  (or_v[i]),
            .sum_o (sum_v[i]),
            .cout  (carry[i+1])
        );
    end

    // Signed overflow: carry into the sign slice disagrees with carry out.
    assign ovf_raw = carry[WIDTH] ^ carry[MSB];
    // True signed less-than: sign of the difference corrected by overflow.
    assign less    = sum_v[MSB] ^ ovf_raw;

    alu32_result_sel #(.WIDTH(WIDTH)) u_sel (
        .kind    (kind),
        .and_v   (and_v),
        .or_v    (or_v),
        .sum_v   (sum_v),
        .less    (less),
        .ovf_raw (ovf_raw),
        .result  (result),
        .ovf     (ovf)
    );

    assign zero = ~|result;

endmodule

// File: rtl/alu32_sliced_chk.sv
module alu32_sliced_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [3:0]       ctrl,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             ovf
);

    always_comb begin
        if (ctrl == 4'b0000) begin
            // R1
            and_result_chk: assert (result == (a_in & b_in))
                else $error("and_result_chk");
        end
        if (ctrl == 4'b0001) begin
            // R2
            or_result_chk: assert (result == (a_in | b_in))
                else $error("or_result_chk");
        end
        if (ctrl == 4'b0010) begin
            // R3
            add_result_chk: assert (result == a_in + b_in)
                else $error("add_result_chk");
        end
        if (ctrl == 4'b1110) begin
            // R4
            sub_result_chk: assert (result == a_in - b_in)
                else $error("sub_result_chk");
        end
        if (ctrl == 4'b1111) begin
            // R5
            slt_result_chk: assert (result ==
                    {{(WIDTH-1){1'b0}}, ($signed(a_in) < $signed(b_in))})
                else $error("slt_result_chk");
        end
        if (ctrl == 4'b0000 || ctrl == 4'b0001 || ctrl == 4'b1111) begin
            // R8
            no_overflow_chk: assert (!ovf)
                else $error("no_overflow_chk");
        end
        if (!(ctrl == 4'b0000 || ctrl == 4'b0001 || ctrl == 4'b0010 ||
              ctrl == 4'b1110 || ctrl == 4'b1111)) begin
            // R9
            unused_code_chk: assert (result == '0 && zero && !ovf)
                else $error("unused_code_chk");
        end
    end

endmodule

bind alu32_sliced alu32_sliced_chk #(.WIDTH(WIDTH)) u_chk (
    .a_in   (a_in),
    .b_in   (b_in),
    .ctrl   (ctrl),
    .result (result),
    .zero   (zero),
    .ovf    (ovf)
);

// File: tb/alu32_sliced_bench.sv
`timescale 1ns/1ps
module alu32_sliced_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [3:0]  ctrl = '0;
    logic [31:0] result;
    logic        zero;
    logic        ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    alu32_sliced u_alu32_sliced (
        .a_in   (a_in),
        .b_in   (b_in),
        .ctrl   (ctrl),
        .result (result),
        .zero   (zero),
        .ovf    (ovf)
    );

    function automatic logic [31:0] exp_result(logic [31:0] a, logic [31:0] b, logic [3:0] c);
        case (c)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b0010: return a + b;
            4'b1110: return a - b;
            4'b1111: return {31'd0, ($signed(a) < $signed(b))};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic [3:0] c);
        logic [31:0] s;
        case (c)
            4'b0010: begin
                s = a + b;
                return (a[31] == b[31]) && (s[31] != a[31]);
            end
            4'b1110: begin
                s = a - b;
                return (a[31] != b[31]) && (s[31] != a[31]);
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic string res_tag(logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b1110: return "R4";
            4'b1111: return "R5";
            default: return "R9";
        endcase
    endfunction

    function automatic string ovf_tag(logic [3:0] c);
        case (c)
            4'b0010, 4'b1110: return "R7";
            4'b0000, 4'b0001, 4'b1111: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h (a=%h b=%h ctrl=%b)",
                     tag, what, act, exp, a_in, b_in, ctrl);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [3:0] c);
        logic [31:0] er;
        @(posedge clk);
        a_in = a;
        b_in = b;
        ctrl = c;
        #5;
        er = exp_result(a, b, c);
        check(res_tag(c), "result", result, er);
        // R6: zero flag follows the expected result
        check("R6", "zero", {31'd0, zero}, {31'd0, (er == 32'd0)});
        check(ovf_tag(c), "ovf", {31'd0, ovf}, {31'd0, exp_ovf(a, b, c)});
    endtask

    task automatic all_valid(logic [31:0] a, logic [31:0] b);
        apply(a, b, 4'b0000);
        apply(a, b, 4'b0001);
        apply(a, b, 4'b0010);
        apply(a, b, 4'b1110);
        apply(a, b, 4'b1111);
    endtask

    initial begin
        void'($urandom(32'd20211));
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #5;
        // Reset state: all-zero inputs, AND code -> result 0, zero high (R1, R6)
        check("R1", "idle result", result, 32'd0);
        check("R6", "idle zero", {31'd0, zero}, 32'd1);

        // Directed sign-boundary pairs (R5, R7)
        all_valid(32'h7FFF_FFFF, 32'h0000_0001);
        all_valid(32'h8000_0000, 32'h0000_0001);
        all_valid(32'h8000_0000, 32'hFFFF_FFFF);
        all_valid(32'h7FFF_FFFF, 32'h8000_0000);
        all_valid(32'h8000_0000, 32'h7FFF_FFFF);
        all_valid(32'hFFFF_FFFF, 32'h0000_0000);
        all_valid(32'h0000_0000, 32'hFFFF_FFFF);
        // Equal operands: subtraction gives zero (R4, R6)
        all_valid(32'h1234_5678, 32'h1234_5678);
        all_valid(32'h8000_0000, 32'h8000_0000);
        // Carry ripple across full width (R3)
        all_valid(32'hFFFF_FFFF, 32'h0000_0001);
        all_valid(32'hAAAA_AAAA, 32'h5555_5555);
        all_valid(32'h0000_0000, 32'h0000_0000);

        // Every unused code (R9)
        for (int c = 0; c < 16; c++) begin
            apply(32'hDEAD_BEEF, 32'h0BAD_F00D, c[3:0]);
        end

        // Constrained random over valid codes, with occasional unused codes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            logic [3:0]  rc;
            int sel;
            ra  = $urandom;
            rb  = $urandom;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    rc = 4'b0000;
                2:       rc = 4'b0001;
                3, 4:    rc = 4'b0010;
                5, 6:    rc = 4'b1110;
                7, 8:    rc = 4'b1111;
                default: rc = 4'($urandom_range(0, 15));
            endcase
            if ($urandom_range(0, 7) == 0) rb = ra;
            apply(ra, rb, rc);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule